// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the address-phase front end of an I2C target. It watches the two bus lines, oversampled by the local clock. On every start or repeated start it shifts in the first byte: seven address bits, most significant first, then the read/write bit. It compares that byte with a static own address and decides whether to acknowledge. When it accepts, it pulls SDA low for the whole ninth clock and emits a one-cycle match pulse. The pulse carries the requested direction and whether the broadcast address was hit.

The all-zero address is a broadcast that is accepted only for writes, and only when broadcast reception is enabled. The reserved group whose upper four address bits are all ones is never accepted, even if the own address falls inside it. After the address phase, and after any refused address, the block stays silent until the next start or repeated start. A repeated start in the middle of an address byte throws away the partial byte and begins again.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is asserted, and directly after it, `sda_pull_o` and `match_o` are 0.
- R2: An address byte whose upper seven bits equal `own_addr_i` and whose last bit is 0 (write) is acknowledged: SDA is held low while SCL is high in the ninth clock. One `match_o` pulse of exactly one clock occurs, with `match_rw_o`=0 and `match_gc_o`=0.
- R3: An own-address byte with last bit 1 (read) is acknowledged the same way, and the pulse reports `match_rw_o`=1.
- R4: A byte whose address differs from `own_addr_i`, and is not an accepted broadcast, gets no acknowledge and no pulse.
- R5: Address 0000000 with the write bit, while `gc_en_i`=1, is acknowledged, and the pulse reports `match_gc_o`=1 and `match_rw_o`=0.
- R6: Address 0000000 with the read bit is never acknowledged.
- R7: Address 0000000 is not acknowledged while `gc_en_i`=0.
- R8: An address whose upper four bits are 1111 is never acknowledged, whatever `own_addr_i` is.
- R9: `sda_pull_o` is asserted only while the synchronized SCL is low, before the ninth rising SCL edge. It is released after the falling SCL edge that ends the ninth clock.
- R10: A repeated start in the middle of an address byte discards the bits received so far and starts a new address byte.
- R11: After the address phase, whether the address was accepted or not, and after a stop, further bytes get no acknowledge and no pulse until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen by the pad |
| sda_i | input | 1 | SDA line level as seen by the pad |
| own_addr_i | input | 7 | Static own 7-bit address |
| gc_en_i | input | 1 | Static enable for broadcast (all-zero) address |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| match_o | output | 1 | One-clock pulse when an address is accepted |
| match_rw_o | output | 1 | Direction of the last accepted address, 1 = read |
| match_gc_o | output | 1 | Last accepted address was the broadcast address |

## Verification
A bit counter that slips by one shifts the assembled byte. That shows at the very next ninth clock: either SDA stays high for a correct address, or a pulse appears for a wrong one. A state machine stuck after the address phase shows up in the first following byte as a stray acknowledge. A release that comes late shows within one SCL low phase, when SDA is still pulled after the ninth falling edge. A bad reserved-group or broadcast decode shows on the single frame that uses such an address, as a wrong SDA level in its ninth clock.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

   localparam int ADDR_W = 7;
   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_WAIT,
      ST_ACK,
      ST_HOLD
   } am_state_t;

   function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
      return (a[ADDR_W-1 -: 4] == 4'hF);
   endfunction

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES:0] chain_q;

   initial begin
      if (STAGES < 2) $fatal(1, "i2c_am_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], d_i};
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
   input  logic scl_lvl_i,
   input  logic sda_rise_i,
   input  logic sda_fall_i,
   output logic start_o,
   output logic stop_o
);

   assign start_o = scl_lvl_i & sda_fall_i;
   assign stop_o  = scl_lvl_i & sda_rise_i;

endmodule

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
   import i2c_am_pkg::*;
#(
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_en_i,
   output logic              accept_o,
   output logic              is_gc_o
);

   logic [ADDR_W-1:0] addr;
   logic              rw;
   logic              own_hit;
   logic              gc_hit;

   assign addr    = byte_i[BYTE_W-1:1];
   assign rw      = byte_i[0];
   assign own_hit = (addr == own_addr_i) && !addr_reserved(addr);

   generate
      if (GC_SUPPORT) begin : g_gc
         assign gc_hit = (addr == '0) && !rw && gc_en_i;
      end else begin : g_no_gc
         logic unused_gc;
         assign unused_gc = gc_en_i;
         assign gc_hit    = 1'b0;
      end
   endgenerate

   assign accept_o = own_hit | gc_hit;
   assign is_gc_o  = gc_hit;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_en_i,
   output logic              sda_pull_o,
   output logic              match_o,
   output logic              match_rw_o,
   output logic              match_gc_o
);

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_ev, stop_ev;

   am_state_t         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] shift_q;
   logic [ADDR_W-1:0] addr_q;
   logic              seen_rise_q;
   logic              rw_q, gc_q;
   logic              pull_q, pulse_q;

   logic              dec_accept, dec_gc;
   logic              last_bit;

   i2c_am_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   i2c_am_cond u_cond (
      .scl_lvl_i(scl_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
      .start_o(start_ev), .stop_o(stop_ev)
   );

   i2c_am_decode #(.GC_SUPPORT(GC_SUPPORT)) u_decode (
      .byte_i({shift_q, sda_lvl}), .own_addr_i(own_addr_i), .gc_en_i(gc_en_i),
      .accept_o(dec_accept), .is_gc_o(dec_gc)
   );

   assign last_bit = (cnt_q == CNT_W'(BYTE_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         shift_q     <= '0;
         addr_q      <= '0;
         seen_rise_q <= 1'b0;
         rw_q        <= 1'b0;
         gc_q        <= 1'b0;
         pull_q      <= 1'b0;
         pulse_q     <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (start_ev) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
         end else if (stop_ev) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shift_q <= {shift_q[ADDR_W-2:0], sda_lvl};
                     cnt_q   <= cnt_q + 1'b1;
                     if (last_bit) begin
                        addr_q <= shift_q;
                        if (dec_accept) begin
                           state_q <= ST_ACK_WAIT;
                           rw_q    <= sda_lvl;
                           gc_q    <= dec_gc;
                        end else begin
                           state_q <= ST_HOLD;
                        end
                     end
                  end
               end
               ST_ACK_WAIT: begin
                  if (scl_fall) begin
                     pull_q      <= 1'b1;
                     pulse_q     <= 1'b1;
                     seen_rise_q <= 1'b0;
                     state_q     <= ST_ACK;
                  end
               end
               ST_ACK: begin
                  if (scl_rise) seen_rise_q <= 1'b1;
                  if (scl_fall && seen_rise_q) begin
                     pull_q  <= 1'b0;
                     state_q <= ST_HOLD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = pull_q;
   assign match_o    = pulse_q;
   assign match_rw_o = rw_q;
   assign match_gc_o = gc_q;

   p_pull_edge_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_q != $past(pull_q)) |-> !$past(scl_lvl));

   p_pull_only_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pull_q |-> (state_q == ST_ACK));

   p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   p_pulse_with_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> pull_q);

   p_own_or_gc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && !gc_q) |-> (addr_q == own_addr_i));

   p_gc_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && gc_q) |-> (!rw_q && addr_q == '0));

   p_gc_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && gc_q) |-> gc_en_i);

   p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> !addr_reserved(addr_q));

endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [6:0] own = 7'h2A;
   logic       gc_en = 1'b1;
   logic       sda_pull, match, match_rw, match_gc;
   logic       sda_line;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;
   logic last_rw = 1'b0, last_gc = 1'b0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   i2c_addr_match u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .own_addr_i(own), .gc_en_i(gc_en),
      .sda_pull_o(sda_pull), .match_o(match),
      .match_rw_o(match_rw), .match_gc_o(match_gc)
   );

   always @(negedge clk) begin
      if (match) begin
         pulses  <= pulses + 1;
         last_rw <= match_rw;
         last_gc <= match_gc;
      end
   end

   // fields: own(7) gc_en(1) addr(7) rw(1) exp_ack(1) exp_gc(1)
   localparam int NV = 9;
   localparam logic [17:0] VEC [0:NV-1] = '{
      {7'h2A, 1'b1, 7'h2A, 1'b0, 1'b1, 1'b0},  // R2
      {7'h2A, 1'b1, 7'h2A, 1'b1, 1'b1, 1'b0},  // R3
      {7'h2A, 1'b1, 7'h2B, 1'b0, 1'b0, 1'b0},  // R4
      {7'h2A, 1'b1, 7'h00, 1'b0, 1'b1, 1'b1},  // R5
      {7'h2A, 1'b1, 7'h00, 1'b1, 1'b0, 1'b0},  // R6
      {7'h2A, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0},  // R7
      {7'h78, 1'b1, 7'h78, 1'b0, 1'b0, 1'b0},  // R8
      {7'h7F, 1'b1, 7'h7F, 1'b1, 1'b0, 1'b0},  // R8
      {7'h55, 1'b0, 7'h55, 1'b1, 1'b1, 1'b0}   // R3
   };

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b0; hw(H);
      scl_m = 1'b0; hw(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b1; hw(H);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    hw(H);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0; hw(H);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   // ninth clock: pre = pull before rise, line = SDA while SCL high, post = pull after fall
   task automatic ack_clock(output logic pre, output logic line, output logic post);
      sda_m = 1'b1; hw(H);
      pre = sda_pull;
      scl_m = 1'b1; hw(H/2);
      line = sda_line; hw(H/2);
      scl_m = 1'b0; hw(H);
      post = sda_pull;
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic pre, line, post;
      int   p0;

      // R1 reset state
      hw(4);
      chk(sda_pull == 1'b0 && match == 1'b0, "R1 outputs during reset", {sda_pull, match}, 0);
      rst_n = 1'b1;
      hw(6);
      chk(sda_pull == 1'b0 && match == 1'b0, "R1 outputs after reset", {sda_pull, match}, 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [17:0] e;
         e     = VEC[v];
         own   = e[17:11];
         gc_en = e[10];
         hw(2);
         p0 = pulses;
         bus_start();
         send_byte(e[9:2]);
         ack_clock(pre, line, post);
         chk(line == ~e[1], $sformatf("R2 R4 vec %0d ack level", v), line, ~e[1]);
         chk(pulses - p0 == int'(e[1]), $sformatf("R2 vec %0d pulse count", v), pulses - p0, e[1]);
         if (e[1]) begin
            chk(last_rw == e[2], $sformatf("R3 vec %0d direction", v), last_rw, e[2]);
            chk(last_gc == e[0], $sformatf("R5 vec %0d broadcast flag", v), last_gc, e[0]);
            chk(pre == 1'b1, $sformatf("R9 vec %0d pull before rise", v), pre, 1);
            chk(post == 1'b0, $sformatf("R9 vec %0d released after fall", v), post, 0);
         end
         bus_stop();
      end

      // R10 repeated start mid-byte
      own = 7'h2A; gc_en = 1'b1;
      p0 = pulses;
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte({7'h2A, 1'b0});
      ack_clock(pre, line, post);
      chk(line == 1'b0, "R10 ack after repeated start", line, 0);
      chk(pulses - p0 == 1, "R10 pulse after repeated start", pulses - p0, 1);

      // R11 data byte after accepted address is not acknowledged
      p0 = pulses;
      send_byte({7'h2A, 1'b0});
      ack_clock(pre, line, post);
      chk(line == 1'b1 && pulses == p0, "R11 no ack on data byte", line, 1);
      bus_stop();

      // R11 bytes after stop without start
      send_byte({7'h2A, 1'b0});
      ack_clock(pre, line, post);
      chk(line == 1'b1 && pulses == p0, "R11 no ack after stop", line, 1);

      // R11 own byte following a refused address
      bus_start();
      send_byte({7'h33, 1'b0});
      ack_clock(pre, line, post);
      chk(line == 1'b1, "R4 refused address", line, 1);
      send_byte({7'h2A, 1'b0});
      ack_clock(pre, line, post);
      chk(line == 1'b1 && pulses == p0, "R11 no ack after refusal", line, 1);
      bus_stop();

      // R10 repeated start right after a refusal
      bus_start();
      send_byte({7'h11, 1'b1});
      ack_clock(pre, line, post);
      bus_start();
      send_byte({7'h2A, 1'b1});
      ack_clock(pre, line, post);
      chk(line == 1'b0 && pulses == p0 + 1, "R10 ack after refusal and restart", line, 0);
      chk(last_rw == 1'b1, "R3 direction after restart", last_rw, 1);
      bus_stop();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule